// File: doc/BRIEF.md
# Clock Synthesizer Configuration Target on a Two-Wire Serial Bus

This block is a target-only two-wire serial bus interface. It holds four 8-bit control bytes that configure a clock synthesizer. SCL and SDA are sampled by a system clock that runs at least eight times faster than SCL. The block has no register pointer: every transaction moves the same fixed burst of four bytes, byte 0 first and byte 3 last.

A write places each received byte in a staging buffer. The four staged bytes are copied into the live registers together, and only when a proper stop condition closes a write that delivered all four bytes. A read returns the live bytes in order. One pin chooses between two target addresses.

Besides the packed register word, the block decodes the synthesizer fields it controls: the feedback-divider code, the spread-spectrum enable, the bypass select and the output-rate select.

Top module: `clkcfg_i2c_target`

## Requirements
- R1: After reset the live bytes are byte0 = 0xF7, byte1 = 0xFF, byte2 = 0xA0 and byte3 = 0x53. `cfg_o` packs byte k into bits [8k+7:8k].
- R2: The target answers the 7-bit address 1001100 when `addr_sel_i` is 0 and 1001110 when it is 1. The eighth address bit is the direction, with 0 meaning write and 1 meaning read. The target acknowledges a matching address.
- R3: After an address that does not match, the target drives no acknowledge. It ignores the bus until the next start, and the live bytes stay unchanged.
- R4: Write data is shifted most significant bit first, and data byte k fills live byte k. Live bytes change only at the stop that ends a write carrying all four bytes, and all four change together.
- R5: A stop that arrives after fewer than four data bytes leaves the live bytes unchanged.
- R6: A repeated start discards the bytes staged so far. A later stop does not commit them.
- R7: A read returns live bytes 0, 1, 2 and 3 in that order, most significant bit first. If the host acknowledges byte 3, the next byte sent is byte 0 again.
- R8: In a write, data bytes after the fourth are neither acknowledged nor staged.
- R9: When the host does not acknowledge a read byte, the target releases SDA and stops driving.
- R10: `fdiv_code_o` carries byte2 bits 6..2. `ss_en_o` is byte2 bit 1, `bypass_o` is byte2 bit 0 and `sel_100m_o` is byte3 bit 7.
- R11: When acknowledging, the target holds SDA low for the whole high phase of the acknowledge clock. It changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| addr_sel_i | input | 1 | Chooses between the two target addresses |
| sda_drive_low_o | output | 1 | Open-drain pull-down request for SDA |
| cfg_o | output | 32 | Live bytes, byte k at bits [8k+7:8k] |
| fdiv_code_o | output | 5 | Feedback-divider code (byte2[6:2]) |
| ss_en_o | output | 1 | Spread-spectrum enable (byte2[1]) |
| bypass_o | output | 1 | PLL bypass select (byte2[0]) |
| sel_100m_o | output | 1 | Output rate select, 1 = 100 MHz (byte3[7]) |

## Verification
The assertions assume that the host changes SDA only while SCL is low, except to form a start or a stop. They also assume that SCL stays at each level for several system clocks, so the synchronised SCL and SDA lines never move in the same cycle. A further assumption is that the host never tries a start or a stop while the target is pulling SDA low.

The bench drives each SCL phase for ten system clocks and changes SDA five clocks into the low phase. It releases SDA during every acknowledge and read slot. This timing keeps the stimulus within those assumptions.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_ADDR_ACK,
    S_WDATA,
    S_WACK,
    S_RDATA,
    S_RACK
  } bus_state_e;

  // positions of decoded fields inside the packed live word
  localparam int FDIV_MSB  = 2 * BYTE_W + 6;
  localparam int FDIV_W    = 5;
  localparam int SS_BIT    = 2 * BYTE_W + 1;
  localparam int BYP_BIT   = 2 * BYTE_W;
  localparam int RATE_BIT  = 3 * BYTE_W + 7;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_prev, sda_prev;

  // idle bus level is high, so the chains reset high to avoid false edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff   <= '1;
      sda_ff   <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_ff   <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff   <= {sda_ff[STAGES-2:0], sda_i};
      scl_prev <= scl_ff[STAGES-1];
      sda_prev <= sda_ff[STAGES-1];
    end
  end

  always_comb begin
    scl_lvl   = scl_ff[STAGES-1];
    sda_lvl   = sda_ff[STAGES-1];
    scl_rise  = scl_lvl & ~scl_prev;
    scl_fall  = ~scl_lvl & scl_prev;
    start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
  end
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import clkcfg_pkg::*;
#(
  parameter int         NBYTES = 4,
  parameter logic [6:0] ADDR_A = 7'b1001100,
  parameter logic [6:0] ADDR_B = 7'b1001110,
  localparam int        IDX_W  = $clog2(NBYTES + 1),
  localparam int        RIDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     scl_lvl,
  input  logic                     sda_lvl,
  input  logic                     scl_rise,
  input  logic                     scl_fall,
  input  logic                     start_det,
  input  logic                     stop_det,
  input  logic                     addr_sel,
  input  logic [NBYTES*BYTE_W-1:0] rd_data,
  output logic                     sda_low,
  output logic                     stage_we,
  output logic [RIDX_W-1:0]        stage_idx,
  output logic [BYTE_W-1:0]        stage_data,
  output logic                     commit
);
  localparam logic [IDX_W-1:0]  WCNT_FULL = IDX_W'(NBYTES);
  localparam logic [RIDX_W-1:0] RIDX_LAST = RIDX_W'(NBYTES - 1);

  bus_state_e        state_q, state_n;
  logic [3:0]        bitcnt_q, bitcnt_n;
  logic [7:0]        shreg_q, shreg_n;
  logic [7:0]        txreg_q, txreg_n;
  logic [IDX_W-1:0]  wcnt_q, wcnt_n;
  logic [RIDX_W-1:0] ridx_q, ridx_n, ridx_nxt;
  logic              is_read_q, is_read_n;
  logic              mack_q, mack_n;
  logic              sda_low_q, sda_low_n;
  logic [6:0]        my_addr;
  logic [7:0]        rd_byte0, rd_byte_nxt;

  assign my_addr     = addr_sel ? ADDR_B : ADDR_A;
  assign ridx_nxt    = (ridx_q == RIDX_LAST) ? '0 : ridx_q + 1'b1;
  assign rd_byte0    = rd_data[BYTE_W-1:0];
  assign rd_byte_nxt = rd_data[{ridx_nxt, 3'b000} +: BYTE_W];

  always_comb begin
    state_n    = state_q;
    bitcnt_n   = bitcnt_q;
    shreg_n    = shreg_q;
    txreg_n    = txreg_q;
    wcnt_n     = wcnt_q;
    ridx_n     = ridx_q;
    is_read_n  = is_read_q;
    mack_n     = mack_q;
    sda_low_n  = sda_low_q;
    stage_we   = 1'b0;
    stage_idx  = wcnt_q[RIDX_W-1:0];
    stage_data = shreg_q;
    commit     = 1'b0;

    if (start_det) begin
      state_n   = S_ADDR;
      bitcnt_n  = '0;
      wcnt_n    = '0;
      sda_low_n = 1'b0;
    end else if (stop_det) begin
      if ((state_q == S_WDATA || state_q == S_WACK) && wcnt_q == WCNT_FULL)
        commit = 1'b1;
      state_n   = S_IDLE;
      sda_low_n = 1'b0;
    end else begin
      unique case (state_q)
        S_ADDR: begin
          if (scl_rise) begin
            shreg_n  = {shreg_q[6:0], sda_lvl};
            bitcnt_n = bitcnt_q + 4'd1;
          end else if (scl_fall && bitcnt_q == 4'd8) begin
            if (shreg_q[7:1] == my_addr) begin
              state_n   = S_ADDR_ACK;
              sda_low_n = 1'b1;
              is_read_n = shreg_q[0];
            end else begin
              state_n   = S_IDLE;
              sda_low_n = 1'b0;
            end
          end
        end
        S_ADDR_ACK: begin
          if (scl_fall) begin
            bitcnt_n = '0;
            if (is_read_q) begin
              state_n   = S_RDATA;
              ridx_n    = '0;
              txreg_n   = rd_byte0;
              sda_low_n = ~rd_byte0[7];
            end else begin
              state_n   = S_WDATA;
              sda_low_n = 1'b0;
            end
          end
        end
        S_WDATA: begin
          if (scl_rise) begin
            shreg_n  = {shreg_q[6:0], sda_lvl};
            bitcnt_n = bitcnt_q + 4'd1;
          end else if (scl_fall && bitcnt_q == 4'd8) begin
            state_n = S_WACK;
            if (wcnt_q < WCNT_FULL) begin
              stage_we  = 1'b1;
              wcnt_n    = wcnt_q + 1'b1;
              sda_low_n = 1'b1;
            end
          end
        end
        S_WACK: begin
          if (scl_fall) begin
            state_n   = S_WDATA;
            bitcnt_n  = '0;
            sda_low_n = 1'b0;
          end
        end
        S_RDATA: begin
          if (scl_rise) begin
            bitcnt_n = bitcnt_q + 4'd1;
          end else if (scl_fall) begin
            if (bitcnt_q == 4'd8) begin
              state_n   = S_RACK;
              sda_low_n = 1'b0;
            end else begin
              txreg_n   = {txreg_q[6:0], 1'b0};
              sda_low_n = ~txreg_q[6];
            end
          end
        end
        S_RACK: begin
          if (scl_rise) begin
            mack_n = ~sda_lvl;
          end else if (scl_fall) begin
            if (mack_q) begin
              state_n   = S_RDATA;
              bitcnt_n  = '0;
              ridx_n    = ridx_nxt;
              txreg_n   = rd_byte_nxt;
              sda_low_n = ~rd_byte_nxt[7];
            end else begin
              state_n   = S_IDLE;
              sda_low_n = 1'b0;
            end
          end
        end
        default: begin
          sda_low_n = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      bitcnt_q  <= '0;
      shreg_q   <= '0;
      txreg_q   <= '0;
      wcnt_q    <= '0;
      ridx_q    <= '0;
      is_read_q <= 1'b0;
      mack_q    <= 1'b0;
      sda_low_q <= 1'b0;
    end else begin
      state_q   <= state_n;
      bitcnt_q  <= bitcnt_n;
      shreg_q   <= shreg_n;
      txreg_q   <= txreg_n;
      wcnt_q    <= wcnt_n;
      ridx_q    <= ridx_n;
      is_read_q <= is_read_n;
      mack_q    <= mack_n;
      sda_low_q <= sda_low_n;
    end
  end

  assign sda_low = sda_low_q;

  // R11: the pull-down only moves while the synchronised clock is low
  p_drive_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_low_q != $past(sda_low_q)) |-> !scl_lvl);

  // R3: an idle target never holds the line
  p_idle_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE) |-> !sda_low_q);

  // R2: the address acknowledge is in place when its clock rises
  p_addr_ack_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_ADDR_ACK && scl_rise) |-> sda_low_q);
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import clkcfg_pkg::*;
#(
  parameter int                       NBYTES      = 4,
  parameter logic [NBYTES*BYTE_W-1:0] RESET_VALUE = 32'h53A0FFF7,
  localparam int                      RIDX_W      = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     stage_we,
  input  logic [RIDX_W-1:0]        stage_idx,
  input  logic [BYTE_W-1:0]        stage_data,
  input  logic                     commit,
  output logic [NBYTES*BYTE_W-1:0] live
);
  logic [BYTE_W-1:0]        stage_q [NBYTES];
  logic [NBYTES*BYTE_W-1:0] live_q;

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    logic stage_en;
    assign stage_en = stage_we && (stage_idx == RIDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[i] <= '0;
      else if (stage_en) stage_q[i] <= stage_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live_q[i*BYTE_W +: BYTE_W] <= RESET_VALUE[i*BYTE_W +: BYTE_W];
      else if (commit) live_q[i*BYTE_W +: BYTE_W] <= stage_q[i];
    end
  end

  assign live = live_q;

  // R4: live bytes hold unless a commit was issued
  p_live_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(live_q));
endmodule

// File: rtl/clkcfg_i2c_target.sv
module clkcfg_i2c_target
  import clkcfg_pkg::*;
#(
  parameter int                       NBYTES      = 4,
  parameter int                       SYNC_STAGES = 2,
  parameter logic [6:0]               ADDR_A      = 7'b1001100,
  parameter logic [6:0]               ADDR_B      = 7'b1001110,
  parameter logic [NBYTES*BYTE_W-1:0] RESET_VALUE = 32'h53A0FFF7,
  localparam int                      CFG_W       = NBYTES * BYTE_W,
  localparam int                      RIDX_W      = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_sel_i,
  output logic              sda_drive_low_o,
  output logic [CFG_W-1:0]  cfg_o,
  output logic [FDIV_W-1:0] fdiv_code_o,
  output logic              ss_en_o,
  output logic              bypass_o,
  output logic              sel_100m_o
);
  logic [1:0]        rst_ff;
  logic              rst_core_n;
  logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic              stage_we, commit;
  logic [RIDX_W-1:0] stage_idx;
  logic [BYTE_W-1:0] stage_data;
  logic [CFG_W-1:0]  live;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= '0;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_core_n = rst_ff[1];

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  i2c_target_fsm #(.NBYTES(NBYTES), .ADDR_A(ADDR_A), .ADDR_B(ADDR_B)) u_fsm (
    .clk(clk), .rst_n(rst_core_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .addr_sel(addr_sel_i), .rd_data(live),
    .sda_low(sda_drive_low_o), .stage_we(stage_we), .stage_idx(stage_idx),
    .stage_data(stage_data), .commit(commit)
  );

  cfg_reg_bank #(.NBYTES(NBYTES), .RESET_VALUE(RESET_VALUE)) u_bank (
    .clk(clk), .rst_n(rst_core_n), .stage_we(stage_we), .stage_idx(stage_idx),
    .stage_data(stage_data), .commit(commit), .live(live)
  );

  always_comb begin
    cfg_o       = live;
    fdiv_code_o = live[FDIV_MSB -: FDIV_W];
    ss_en_o     = live[SS_BIT];
    bypass_o    = live[BYP_BIT];
    sel_100m_o  = live[RATE_BIT];
  end
endmodule

// File: tb/clkcfg_i2c_target_test.sv
module clkcfg_i2c_target_test;
  localparam int Q = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_scl = 1'b1;
  logic        m_sda = 1'b1;
  logic        addr_sel = 1'b0;
  logic        drive_low;
  logic        sda_line;
  logic [31:0] cfg;
  logic [4:0]  fdiv;
  logic        ss_en, byp, sel100;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  assign sda_line = m_sda & ~drive_low;

  clkcfg_i2c_target uut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .addr_sel_i(addr_sel), .sda_drive_low_o(drive_low), .cfg_o(cfg),
    .fdiv_code_o(fdiv), .ss_en_o(ss_en), .bypass_o(byp), .sel_100m_o(sel100)
  );

  // {addr_sel, word}; word byte k = data byte k
  localparam logic [32:0] VEC [4] = '{
    {1'b0, 32'h807F1234},
    {1'b1, 32'h00AA55C3},
    {1'b0, 32'hFF00FF00},
    {1'b1, 32'h1B2E3D4C}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; w(Q); m_scl = 1'b1; w(2*Q);
    m_sda = 1'b0; w(2*Q); m_scl = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; w(Q); m_scl = 1'b1; w(2*Q);
    m_sda = 1'b1; w(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic a0;
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; w(Q); m_scl = 1'b1; w(2*Q); m_scl = 1'b0; w(Q);
    end
    m_sda = 1'b1; w(Q); m_scl = 1'b1; w(1);
    a0 = ~sda_line; w(2*Q-2);
    ack = a0 & ~sda_line; w(1);
    m_scl = 1'b0; w(Q);
  endtask

  task automatic read_byte(input logic host_ack, output logic [7:0] d);
    d = '0;
    for (int i = 0; i < 8; i++) begin
      m_sda = 1'b1; w(Q); m_scl = 1'b1; w(Q);
      d = {d[6:0], sda_line}; w(Q); m_scl = 1'b0; w(Q);
    end
    m_sda = ~host_ack; w(Q); m_scl = 1'b1; w(2*Q); m_scl = 1'b0; w(Q);
  endtask

  task automatic write_bytes(input logic [7:0] adr, input logic [31:0] word,
                             input int n, output logic addr_ack);
    logic a;
    send_byte(adr, addr_ack);
    for (int k = 0; k < n; k++) send_byte(word[k*8 +: 8], a);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic        a;
    logic [7:0]  d;
    logic [31:0] cur;
    w(4); rst_n = 1'b1; w(6);

    // R1 / R10: reset state
    chk("R1 reset word", cfg, 32'h53A0FFF7);
    chk("R10 fdiv reset", {27'd0, fdiv}, 32'd8);
    chk("R10 ss/byp/sel reset", {29'd0, ss_en, byp, sel100}, 32'd0);
    chk("R11 no drive at reset", {31'd0, drive_low}, 32'd0);
    cur = 32'h53A0FFF7;

    // table of write/readback transactions
    for (int i = 0; i < 4; i++) begin
      logic [31:0] word;
      logic [7:0]  adr;
      word = VEC[i][31:0];
      addr_sel = VEC[i][32];
      adr = addr_sel ? 8'h9C : 8'h98;
      bus_start();
      write_bytes(adr, word, 4, a);
      chk("R2 address ack", {31'd0, a}, 32'd1);
      chk("R4 unchanged before stop", cfg, cur);
      bus_stop(); w(4);
      chk("R4 committed at stop", cfg, word);
      chk("R10 fields", {21'd0, fdiv, ss_en, byp, sel100, 3'd0},
          {21'd0, word[22:18], word[17], word[16], word[31], 3'd0});
      cur = word;
      bus_start();
      send_byte(adr | 8'h01, a);
      chk("R2 read address ack", {31'd0, a}, 32'd1);
      for (int k = 0; k < 4; k++) begin
        read_byte(k != 3, d);
        chk("R7 readback byte", {24'd0, d}, {24'd0, word[k*8 +: 8]});
      end
      chk("R9 released after host nack", {31'd0, drive_low}, 32'd0);
      bus_stop(); w(4);
    end

    // R3: wrong address for either select setting
    addr_sel = 1'b0;
    bus_start();
    write_bytes(8'h9C, 32'h01020304, 4, a);
    chk("R3 no ack on mismatch", {31'd0, a}, 32'd0);
    bus_stop(); w(4);
    chk("R3 live unchanged", cfg, cur);
    addr_sel = 1'b1;
    bus_start();
    write_bytes(8'h98, 32'h05060708, 4, a);
    chk("R3 no ack on mismatch sel1", {31'd0, a}, 32'd0);
    bus_stop(); w(4);
    chk("R3 live unchanged sel1", cfg, cur);

    // R5: premature stop after two bytes
    addr_sel = 1'b0;
    bus_start();
    write_bytes(8'h98, 32'hDEADBEEF, 2, a);
    bus_stop(); w(4);
    chk("R5 short write discarded", cfg, cur);

    // R6: repeated start discards staged bytes
    bus_start();
    write_bytes(8'h98, 32'hCAFEF00D, 4, a);
    bus_start();
    bus_stop(); w(4);
    chk("R6 repeated start discards", cfg, cur);

    // R8: fifth byte not acknowledged nor staged
    bus_start();
    write_bytes(8'h98, 32'h13579BDF, 4, a);
    send_byte(8'hEE, a);
    chk("R8 fifth byte nack", {31'd0, a}, 32'd0);
    bus_stop(); w(4);
    chk("R8 first four committed", cfg, 32'h13579BDF);
    cur = 32'h13579BDF;

    // R7 wrap: host acknowledges byte 3, byte 0 follows
    bus_start();
    send_byte(8'h99, a);
    for (int k = 0; k < 4; k++) read_byte(1'b1, d);
    read_byte(1'b0, d);
    chk("R7 wrap to byte0", {24'd0, d}, {24'd0, cur[7:0]});
    w(2);
    chk("R9 release after wrap nack", {31'd0, drive_low}, 32'd0);
    bus_stop(); w(4);
    chk("R4 read leaves live intact", cfg, cur);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule